// File: doc/BRIEF.md
# UART Receive Character Queue

This block stores characters arriving from a UART receiver until software reads them. Each stored entry is 12 bits wide: the received byte in bits [7:0], and above it the framing error at bit 8, the parity error at bit 9, the break indication at bit 10 and the overrun indication at bit 11. The storage is a circular buffer of sixteen entries. It is addressed by a wrapping head pointer and an occupancy count, and the slot for the next write is the head plus the count, modulo the depth.

The receiver offers characters on a push port and watches a ready output. A line-break event needs no port of its own from the receiver: it is stored as a status-only entry. A read of the data register pops the head entry. That read also copies the entry's four status bits into a receive-status register, and any write to that register clears it. The block produces the receive-empty and receive-full bits of the flag register and a level-type receive interrupt.

A FIFO-enable input, driven from the line-control register, selects between a sixteen-deep queue and a single-entry holding register. Changing this input at run time discards whatever is queued.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, the flag byte is 0x90: bit 7 (transmit empty) is 1, bit 6 (receive full) is 0, bit 5 (transmit full) is 0 and bit 4 (receive empty) is 1. At the same time the interrupt is low, push-ready is high and the status output is 0.
- R2: With FIFO enable high, up to 16 entries are accepted and read back in arrival order. Push-ready is high while the count is below 16. Receive full sets on the push that brings the count to 16. A push while not ready is dropped.
- R3: With FIFO enable low, push-ready is high only while the count is 0. Receive full sets on the push of the first entry.
- R4: A data-register read presents the head entry on the read-data port and clears receive full. It advances the head and decrements the count only when the count is nonzero, and it sets receive empty whenever the count after the read is zero.
- R5: An accepted push clears receive empty.
- R6: A read loads the status output with bits [11:8] of the popped entry. A write to the status register clears it, and the clear wins when a read and a write occur together.
- R7: A break event stores the entry 0x400, which has zero data and only bit 10 set. If a data push arrives in the same cycle as a break, only the break entry is stored.
- R8: The interrupt sets when an accepted push makes the count equal the trigger level (parameter, default 1). It clears when a read leaves the count at the trigger level minus one.
- R9: A change of FIFO enable zeroes the count and the head pointer. In that cycle any push or read is ignored. The flag bits and the interrupt keep their values until the next push or read.
- R10: A push and a read in the same cycle are both applied: the head entry leaves, the new entry joins at the tail, and the count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifoEn | input | 1 | FIFO enable from line control: 1 selects 16-deep, 0 selects single entry |
| pushValid | input | 1 | Receiver offers a character |
| pushEntry | input | 12 | Offered entry: data [7:0], framing 8, parity 9, break 10, overrun 11 |
| brkEvt | input | 1 | Line-break event; stores the entry 0x400 |
| pushReady | output | 1 | Queue can accept an entry this cycle |
| rdStrobe | input | 1 | Data-register read; pops the head entry |
| rdData | output | 12 | Entry at the head pointer |
| statWr | input | 1 | Write to the receive-status register; clears it |
| statOut | output | 4 | Receive-status register: overrun, break, parity, framing |
| flagsOut | output | 8 | Flag register byte: transmit empty 7, receive full 6, transmit full 5, receive empty 4 |
| rxIrq | output | 1 | Receive interrupt level |

## Verification
Several behaviours are checked on every cycle from the ports alone. An accepted push always clears receive empty, a single-entry push always raises receive full, the status register always follows a read or a clear, and the interrupt never rises without a push. Other behaviours can only be shown by the bench's scenarios. These are the ordering of sixteen entries through the wrapping pointer and the dropping of a push into a full queue. They also include the flush on a FIFO-enable change, which leaves stale flags in place, the break entry winning over a same-cycle character, and the unchanged occupancy under a simultaneous push and read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int QDEPTH = 16;
  localparam int QPTR_W = $clog2(QDEPTH);
  localparam int ENT_W  = 12;
  localparam logic [ENT_W-1:0] BRK_ENTRY = 12'h400;

  typedef logic [ENT_W-1:0] entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              selBrk;
    logic [QPTR_W-1:0] wrIdx;
    logic [QPTR_W-1:0] rdIdx;
    logic              statLoad;
    logic              statClr;
  } qctl_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = QDEPTH,
  parameter int TRIG  = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fifoEn,
  input  logic  pushValid,
  input  logic  brkEvt,
  input  logic  rdStrobe,
  input  logic  statWr,
  output logic  pushReady,
  output logic  rxFull,
  output logic  rxEmpty,
  output logic  rxIrq,
  output qctl_t ctl
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIG_C   = CNT_W'(TRIG);
  localparam logic [CNT_W-1:0] TRIG_LO  = CNT_W'(TRIG - 1);

  logic [CNT_W-1:0] count, cntAfterPop, cntNext;
  logic [PTR_W-1:0] headPtr;
  logic             fifoEnQ;
  logic             flush, pushReq, pushEff, popReq, popEff;

  assign flush     = fifoEn != fifoEnQ;
  assign pushReq   = pushValid | brkEvt;
  assign pushReady = fifoEn ? (count < CNT_MAX) : (count == '0);
  assign pushEff   = pushReq & pushReady & ~flush;
  assign popReq    = rdStrobe & ~flush;
  assign popEff    = popReq & (count != '0);

  assign cntAfterPop = count - CNT_W'(popEff);
  assign cntNext     = cntAfterPop + CNT_W'(pushEff);

  always_comb begin
    ctl.wrEn     = pushEff;
    ctl.selBrk   = brkEvt;
    ctl.wrIdx    = headPtr + count[PTR_W-1:0];
    ctl.rdIdx    = headPtr;
    ctl.statLoad = popReq;
    ctl.statClr  = statWr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      headPtr <= '0;
      fifoEnQ <= 1'b0;
      rxFull  <= 1'b0;
      rxEmpty <= 1'b1;
      rxIrq   <= 1'b0;
    end else begin
      fifoEnQ <= fifoEn;
      if (flush) begin
        count   <= '0;
        headPtr <= '0;
      end else begin
        count <= cntNext;
        if (popEff) headPtr <= headPtr + PTR_W'(1);
        // full: push condition wins over read clear
        if (pushEff && (!fifoEn || cntNext == CNT_MAX)) rxFull <= 1'b1;
        else if (popReq)                                rxFull <= 1'b0;
        // empty: push wins over read set
        if (pushEff)                            rxEmpty <= 1'b0;
        else if (popReq && cntNext == '0)       rxEmpty <= 1'b1;
        // interrupt on exact trigger crossings
        if (pushEff && cntNext == TRIG_C)            rxIrq <= 1'b1;
        else if (popReq && cntAfterPop == TRIG_LO)   rxIrq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = QDEPTH,
  parameter int EW    = ENT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  qctl_t         ctl,
  input  logic [EW-1:0] pushEntry,
  output logic [EW-1:0] rdData,
  output logic [EW-9:0] statOut
);
  localparam int SW = EW - 8;

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] wrData;

  assign wrData = ctl.selBrk ? EW'(BRK_ENTRY) : pushEntry;
  assign rdData = mem[ctl.rdIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.wrEn) begin
      mem[ctl.wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            statOut <= '0;
    else if (ctl.statClr)  statOut <= '0;
    else if (ctl.statLoad) statOut <= rdData[EW-1:8];
  end

  logic [SW-1:0] unusedChk;
  assign unusedChk = statOut;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = QDEPTH,
  parameter int TRIG  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifoEn,
  input  logic              pushValid,
  input  logic [ENT_W-1:0]  pushEntry,
  input  logic              brkEvt,
  output logic              pushReady,
  input  logic              rdStrobe,
  output logic [ENT_W-1:0]  rdData,
  input  logic              statWr,
  output logic [ENT_W-9:0]  statOut,
  output logic [7:0]        flagsOut,
  output logic              rxIrq
);
  qctl_t ctl;
  logic  rxFull, rxEmpty;

  rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .pushValid(pushValid),
    .brkEvt(brkEvt), .rdStrobe(rdStrobe), .statWr(statWr),
    .pushReady(pushReady), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxIrq(rxIrq), .ctl(ctl)
  );

  rxq_data #(.DEPTH(DEPTH), .EW(ENT_W)) data_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pushEntry(pushEntry),
    .rdData(rdData), .statOut(statOut)
  );

  // transmit side is elsewhere: report it empty and not full
  assign flagsOut = {1'b1, rxFull, 1'b0, rxEmpty, 4'b0000};
endmodule

// File: rtl/rx_char_queue_chk.sv
module rx_char_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifoEn,
  input logic        pushValid,
  input logic        brkEvt,
  input logic        pushReady,
  input logic        rdStrobe,
  input logic [11:0] rdData,
  input logic        statWr,
  input logic [3:0]  statOut,
  input logic [7:0]  flagsOut,
  input logic        rxIrq
);
  logic enPrev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) enPrev <= 1'b0;
    else        enPrev <= fifoEn;

  // R3: single-entry push raises receive full
  assert_single_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifoEn && fifoEn == enPrev && pushReady && (pushValid || brkEvt) && !rdStrobe)
      |=> flagsOut[6]);

  // R5: accepted push clears receive empty
  assert_push_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pushReady && (pushValid || brkEvt) && fifoEn == enPrev) |=> !flagsOut[4]);

  // R6: write clears the status register
  assert_stat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    statWr |=> statOut == 4'h0);

  // R6: read loads upper bits of the popped entry
  assert_stat_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !statWr && fifoEn == enPrev) |=> statOut == $past(rdData[11:8]));

  // R8: interrupt rises only after a push request
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxIrq) |-> $past(pushValid || brkEvt));
endmodule

bind rx_char_queue rx_char_queue_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .pushValid(pushValid),
  .brkEvt(brkEvt), .pushReady(pushReady), .rdStrobe(rdStrobe),
  .rdData(rdData), .statWr(statWr), .statOut(statOut),
  .flagsOut(flagsOut), .rxIrq(rxIrq)
);

// File: tb/rx_char_queue_tb_top.sv
module rx_char_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifoEn = 1'b0, pushValid = 1'b0, brkEvt = 1'b0;
  logic        rdStrobe = 1'b0, statWr = 1'b0;
  logic [11:0] pushEntry = '0;
  logic        pushReady, rxIrq;
  logic [11:0] rdData;
  logic [3:0]  statOut;
  logic [7:0]  flagsOut;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [11:0] expQ[$];

  always #10 clk = ~clk;

  rx_char_queue dut_i (
    .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .pushValid(pushValid),
    .pushEntry(pushEntry), .brkEvt(brkEvt), .pushReady(pushReady),
    .rdStrobe(rdStrobe), .rdData(rdData), .statWr(statWr),
    .statOut(statOut), .flagsOut(flagsOut), .rxIrq(rxIrq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // driver: offer an entry, record it as expected if accepted
  task automatic pushItem(input logic [11:0] e, input bit brk, input bit both);
    @(posedge clk); #1;
    pushEntry = e; pushValid = !brk || both; brkEvt = brk;
    #4;
    if (pushReady) expQ.push_back(brk ? 12'h400 : e);
    @(posedge clk); #1;
    pushValid = 0; brkEvt = 0;
    #4;
  endtask

  // monitor: read the head and compare against the scoreboard
  task automatic popItem(input string tag);
    logic [11:0] e;
    @(posedge clk); #1;
    rdStrobe = 1;
    #4;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      chk(rdData == e, tag, rdData, e);
    end
    @(posedge clk); #1;
    rdStrobe = 0;
    #4;
  endtask

  task automatic pushPop(input logic [11:0] e, input string tag);
    logic [11:0] h;
    @(posedge clk); #1;
    pushEntry = e; pushValid = 1; rdStrobe = 1;
    #4;
    h = expQ.pop_front();
    chk(rdData == h, tag, rdData, h);
    if (pushReady) expQ.push_back(e);
    @(posedge clk); #1;
    pushValid = 0; rdStrobe = 0;
    #4;
  endtask

  task automatic setEn(input logic v);
    @(posedge clk); #1;
    fifoEn = v;
    expQ.delete();
    @(posedge clk); #5;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #4;
    // R1 reset state
    chk(flagsOut == 8'h90, "R1 flags", flagsOut, 8'h90);
    chk(rxIrq == 0, "R1 irq", rxIrq, 0);
    chk(pushReady == 1, "R1 ready", pushReady, 1);
    chk(statOut == 0, "R1 status", statOut, 0);

    setEn(1'b1);
    // R5 / R8: push sets irq, clears empty
    pushItem(12'h041, 0, 0);
    chk(flagsOut[4] == 0, "R5 empty cleared", flagsOut[4], 0);
    chk(rxIrq == 1, "R8 irq set", rxIrq, 1);
    pushItem(12'h342, 0, 0);
    pushItem(12'h843, 0, 0);
    popItem("R4 order 0");
    popItem("R4 order 1");
    chk(statOut == 4'h3, "R6 status load", statOut, 3);
    chk(rxIrq == 1, "R8 irq holds", rxIrq, 1);
    popItem("R4 order 2");
    chk(statOut == 4'h8, "R6 overrun status", statOut, 8);
    chk(flagsOut[4] == 1, "R4 empty set", flagsOut[4], 1);
    chk(rxIrq == 0, "R8 irq cleared", rxIrq, 0);
    // R6 clear
    @(posedge clk); #1 statWr = 1;
    @(posedge clk); #1 statWr = 0; #4;
    chk(statOut == 0, "R6 status cleared", statOut, 0);

    // R2 fill to 16 (pointer now wraps)
    for (int i = 0; i < 16; i++) pushItem(12'(8'h10 + i), 0, 0);
    chk(flagsOut[6] == 1, "R2 full at 16", flagsOut[6], 1);
    chk(pushReady == 0, "R2 ready low", pushReady, 0);
    pushItem(12'h0ff, 0, 0);
    chk(expQ.size() == 16, "R2 drop when full", expQ.size(), 16);
    popItem("R2 first out");
    chk(flagsOut[6] == 0, "R4 full cleared", flagsOut[6], 0);
    for (int i = 1; i < 16; i++) popItem("R2 order");
    chk(flagsOut == 8'h90, "R2 drained", flagsOut, 8'h90);

    // R4 read when empty
    popItem("R4 empty read");
    chk(flagsOut[4] == 1 && rxIrq == 0, "R4 empty read flags", {flagsOut[4], rxIrq}, 2);

    // R10 simultaneous push and read
    pushItem(12'h0a1, 0, 0);
    pushItem(12'h0a2, 0, 0);
    pushPop(12'h0a3, "R10 head");
    chk(expQ.size() == 2, "R10 count", expQ.size(), 2);
    popItem("R10 next");
    popItem("R10 tail");
    chk(flagsOut[4] == 1, "R10 drained", flagsOut[4], 1);

    // R7 break wins over data
    pushItem(12'h055, 1, 1);
    popItem("R7 break entry");
    chk(statOut == 4'h4, "R7 break status", statOut, 4);

    // R9 flush on enable change, with a push in that cycle
    pushItem(12'h061, 0, 0);
    pushItem(12'h062, 0, 0);
    @(posedge clk); #1;
    fifoEn = 0; pushEntry = 12'h077; pushValid = 1;
    expQ.delete();
    @(posedge clk); #1 pushValid = 0; #4;
    chk(pushReady == 1, "R9 count zeroed", pushReady, 1);
    chk(flagsOut[4] == 0 && rxIrq == 1, "R9 flags kept", {flagsOut[4], rxIrq}, 1);

    // R3 single entry mode
    pushItem(12'h0c5, 0, 0);
    chk(flagsOut[6] == 1, "R3 full after one", flagsOut[6], 1);
    chk(pushReady == 0, "R3 ready low", pushReady, 0);
    pushItem(12'h0c6, 0, 0);
    popItem("R3 held entry");
    chk(flagsOut == 8'h90 && rxIrq == 0, "R3 after read", flagsOut, 8'h90);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule